// File: doc/BRIEF.md
# Three-wire display command receiver

This block sits behind a strobe/clock/data serial link from a host controller and turns the bit stream into display settings and display-memory writes. The three link pins are brought into the system clock domain through synchronizer chains. Rising edges of the serial clock that arrive while the strobe is low capture one bit each. Bits are assembled least-significant first into bytes. The first complete byte after the strobe falls is a command. Every later complete byte in the same strobe-low frame is display data.

Commands choose the scan mode (digit/segment split), the data-write behaviour (auto-increment or fixed address, test flag, write selector), the write address, and the display control (on/off plus a 3-bit dimming code). Data bytes go out on a write port to an external 14-byte display RAM. The scan mode, dimming code and display-on bit drive the scanner. The write port carries only a one-cycle valid and has no back-pressure, because the serial link has no way to stall. The RAM must accept a write on any cycle, and at most one write occurs per eight serial clocks. Every byte takes effect in the system-clock cycle after its eighth bit is captured, not when the strobe rises.

Top module: `disp_cmd_rx`

## Requirements
- R1: After reset, scan_mode is 2'b11, dim_code is 3'b000, disp_on is 0, test_mode is 0, the write address is 0 and wr_valid is low.
- R2: A bit is taken from ser_dat on each rising ser_clk edge while ser_stb is low, and bytes are assembled least-significant bit first. ser_clk activity while ser_stb is high has no effect.
- R3: The first complete byte after ser_stb falls is decoded as a command. Every later complete byte in the same low period is a data byte.
- R4: If ser_stb rises before eight bits of a byte are captured, that partial byte is discarded, and the next frame starts with a fresh command byte.
- R5: Command bits 7:6 select the type: 00 = mode (bits 1:0 give scan_mode), 01 = data setting (bit 3 = test flag, bit 2 = fixed address, bits 1:0 = write selector), 10 = display control, 11 = address (bits 3:0).
- R6: A data byte is written with one wr_valid pulse at the current address when the write selector is 00 and the address is 0x00 to 0x0D.
- R7: With the fixed-address bit at 0, the address advances by one after each write. With it at 1, the address stays unchanged.
- R8: While the address is 0x0E or above, data bytes are dropped with no write until an address command sets a valid address. Advancing past 0x0D moves into this range.
- R9: A mode command whose value differs from scan_mode updates scan_mode and forces disp_on to 0. A mode command carrying the current value changes nothing.
- R10: A display-control command loads dim_code from bits 2:0 and disp_on from bit 3.
- R11: While the write selector is not 00, data bytes produce no write. test_mode shows the stored test flag.
- R12: A command takes effect while ser_stb is still low, a few system cycles after its eighth bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_stb | input | 1 | Serial frame strobe, active low |
| ser_clk | input | 1 | Serial shift clock, bits taken on rising edges |
| ser_dat | input | 1 | Serial data, least-significant bit first |
| wr_valid | output | 1 | One-cycle display RAM write strobe |
| wr_addr | output | 4 | Display RAM write address |
| wr_data | output | 8 | Display RAM write data |
| scan_mode | output | 2 | Scan mode for the scanner |
| dim_code | output | 3 | Dimming code |
| disp_on | output | 1 | Display enable |
| test_mode | output | 1 | Stored test flag |

## Verification
A corrupted address register shows up within one data byte: the write lands at the wrong wr_addr, or a write appears or goes missing at the 0x0D/0x0E boundary. The scoreboard compares every write against an ordered list of expected address/data pairs and then confirms that the list has been drained. A bit counter or command flag left in the wrong state after an aborted byte shows up as the next frame's first byte being handled as data, or as misaligned bits. Corrupted control registers show on scan_mode, dim_code and disp_on a few cycles after the command's eighth bit, while the strobe is still low.

// File: rtl/disp_rx_pkg.sv
package disp_rx_pkg;
  localparam int BYTE_W = 8;
  localparam int MODE_W = 2;
  localparam int DIM_W  = 3;

  typedef enum logic [1:0] {
    OP_MODE = 2'b00,
    OP_DSET = 2'b01,
    OP_DCTL = 2'b10,
    OP_ADDR = 2'b11
  } op_e;
endpackage

// File: rtl/link_sync.sv
module link_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_stb,
  input  logic ser_clk,
  input  logic ser_dat,
  output logic bit_valid,
  output logic bit_val,
  output logic frame_idle
);
  logic [SYNC_STAGES-1:0] stb_q, sck_q, dat_q;
  logic stb_now, sck_now, sck_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q <= '1;
      sck_q <= '1;
      dat_q <= '0;
      sck_d <= 1'b1;
    end else begin
      stb_q[0] <= ser_stb;
      sck_q[0] <= ser_clk;
      dat_q[0] <= ser_dat;
      for (int i = 1; i < SYNC_STAGES; i++) begin
        stb_q[i] <= stb_q[i-1];
        sck_q[i] <= sck_q[i-1];
        dat_q[i] <= dat_q[i-1];
      end
      sck_d <= sck_now;
    end
  end

  assign stb_now    = stb_q[SYNC_STAGES-1];
  assign sck_now    = sck_q[SYNC_STAGES-1];
  assign bit_val    = dat_q[SYNC_STAGES-1];
  assign frame_idle = stb_now;
  assign bit_valid  = sck_now & ~sck_d & ~stb_now;
endmodule

// File: rtl/byte_shifter.sv
module byte_shifter
  import disp_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_valid,
  input  logic              bit_val,
  input  logic              frame_idle,
  output logic              byte_valid,
  output logic [BYTE_W-1:0] byte_data,
  output logic              byte_is_cmd
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  logic [BYTE_W-1:0] sh;
  logic [CNT_W-1:0]  cnt;
  logic              first;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh          <= '0;
      cnt         <= '0;
      first       <= 1'b1;
      byte_valid  <= 1'b0;
      byte_data   <= '0;
      byte_is_cmd <= 1'b0;
    end else begin
      byte_valid <= 1'b0;
      if (frame_idle) begin
        cnt   <= '0;
        first <= 1'b1;
      end else if (bit_valid) begin
        sh <= {bit_val, sh[BYTE_W-1:1]};
        if (cnt == LAST) begin
          cnt         <= '0;
          byte_valid  <= 1'b1;
          byte_data   <= {bit_val, sh[BYTE_W-1:1]};
          byte_is_cmd <= first;
          first       <= 1'b0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R4: strobe high leaves no partial byte behind
  assert_partial_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_idle |=> (cnt == '0));

  // R2: a byte needs several serial edges, never two back to back
  assert_byte_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |=> !byte_valid);

  // R3: a byte seen while the strobe is high cannot be produced
  assert_first_is_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && $past(frame_idle)) |-> 1'b0);
endmodule

// File: rtl/cmd_regs.sv
module cmd_regs
  import disp_rx_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int RAM_DEPTH = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_valid,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic              byte_is_cmd,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic [MODE_W-1:0] scan_mode,
  output logic [DIM_W-1:0]  dim_code,
  output logic              disp_on,
  output logic              test_mode
);
  localparam logic [ADDR_W:0] DEPTH_V = (ADDR_W+1)'(RAM_DEPTH);

  logic [ADDR_W-1:0] addr;
  logic              fixed_addr;
  logic [1:0]        wr_sel;
  logic              addr_ok;
  op_e               op;

  assign op      = op_e'(byte_data[7:6]);
  assign addr_ok = {1'b0, addr} < DEPTH_V;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr       <= '0;
      fixed_addr <= 1'b0;
      wr_sel     <= 2'b00;
      test_mode  <= 1'b0;
      scan_mode  <= '1;
      dim_code   <= '0;
      disp_on    <= 1'b0;
      wr_valid   <= 1'b0;
      wr_addr    <= '0;
      wr_data    <= '0;
    end else begin
      wr_valid <= 1'b0;
      if (byte_valid && byte_is_cmd) begin
        case (op)
          OP_MODE: begin
            if (byte_data[MODE_W-1:0] != scan_mode) begin
              scan_mode <= byte_data[MODE_W-1:0];
              disp_on   <= 1'b0;
            end
          end
          OP_DSET: begin
            test_mode  <= byte_data[3];
            fixed_addr <= byte_data[2];
            wr_sel     <= byte_data[1:0];
          end
          OP_DCTL: begin
            disp_on  <= byte_data[3];
            dim_code <= byte_data[DIM_W-1:0];
          end
          OP_ADDR: addr <= byte_data[ADDR_W-1:0];
          default: ;
        endcase
      end else if (byte_valid) begin
        if (wr_sel == 2'b00 && addr_ok) begin
          wr_valid <= 1'b1;
          wr_addr  <= addr;
          wr_data  <= byte_data;
          if (!fixed_addr) addr <= addr + 1'b1;
        end
      end
    end
  end

  // R6: writes only ever target the valid window
  assert_wr_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> ({1'b0, wr_addr} < DEPTH_V));

  // R8: data arriving at an invalid address is dropped
  assert_drop_invalid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && !byte_is_cmd && !addr_ok) |=> !wr_valid);

  // R7: fixed addressing never moves the pointer on data
  assert_fixed_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && !byte_is_cmd && fixed_addr) |=> (addr == $past(addr)));

  // R9: a mode change always leaves the display blanked
  assert_mode_blank_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_mode != $past(scan_mode)) |-> !disp_on);
endmodule

// File: rtl/disp_cmd_rx.sv
module disp_cmd_rx
  import disp_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 4,
  parameter int RAM_DEPTH   = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_stb,
  input  logic              ser_clk,
  input  logic              ser_dat,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic [1:0]        scan_mode,
  output logic [2:0]        dim_code,
  output logic              disp_on,
  output logic              test_mode
);
  logic              bit_valid, bit_val, frame_idle;
  logic              byte_valid, byte_is_cmd;
  logic [BYTE_W-1:0] byte_data;

  link_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .ser_stb(ser_stb), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .bit_valid(bit_valid), .bit_val(bit_val), .frame_idle(frame_idle)
  );

  byte_shifter u_shift (
    .clk(clk), .rst_n(rst_n),
    .bit_valid(bit_valid), .bit_val(bit_val), .frame_idle(frame_idle),
    .byte_valid(byte_valid), .byte_data(byte_data), .byte_is_cmd(byte_is_cmd)
  );

  cmd_regs #(.ADDR_W(ADDR_W), .RAM_DEPTH(RAM_DEPTH)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .byte_valid(byte_valid), .byte_data(byte_data), .byte_is_cmd(byte_is_cmd),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .scan_mode(scan_mode), .dim_code(dim_code), .disp_on(disp_on),
    .test_mode(test_mode)
  );
endmodule

// File: tb/disp_cmd_rx_tb.sv
module disp_cmd_rx_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_stb = 1'b1, ser_clk = 1'b1, ser_dat = 1'b0;
  logic       wr_valid;
  logic [3:0] wr_addr;
  logic [7:0] wr_data;
  logic [1:0] scan_mode;
  logic [2:0] dim_code;
  logic       disp_on, test_mode;

  int checks = 0, failures = 0, cycles = 0;
  bit done = 1'b0;
  logic [11:0] exp_q[$];
  string       tag_q[$];
  logic [7:0]  fb [0:7];

  always #5 clk = ~clk;

  disp_cmd_rx u_dut (
    .clk(clk), .rst_n(rst_n), .ser_stb(ser_stb), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .scan_mode(scan_mode), .dim_code(dim_code), .disp_on(disp_on), .test_mode(test_mode)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      ser_clk = 1'b0; ser_dat = b[i]; cyc(4);
      ser_clk = 1'b1; cyc(4);
    end
  endtask

  task automatic frame(input int n);
    ser_stb = 1'b0; cyc(4);
    for (int k = 0; k < n; k++) send_bits(fb[k], 8);
    cyc(4); ser_stb = 1'b1; cyc(10);
  endtask

  task automatic cmd(input logic [7:0] c);
    fb[0] = c; frame(1);
  endtask

  task automatic expect_wr(input logic [3:0] a, input logic [7:0] d, input string tag);
    exp_q.push_back({a, d});
    tag_q.push_back(tag);
  endtask

  task automatic drained(input string tag);
    cyc(6);
    chk(exp_q.size() == 0, tag, exp_q.size(), 0);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && wr_valid && !done) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R8 unexpected write", {wr_addr, wr_data}, 0);
      end else begin
        logic [11:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({wr_addr, wr_data} == e, t, {wr_addr, wr_data}, e);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(3);
    // R1 reset state
    chk(scan_mode == 2'b11, "R1 scan_mode", scan_mode, 3);
    chk(dim_code == 3'd0 && !disp_on && !test_mode, "R1 dim/on/test",
        {dim_code, disp_on, test_mode}, 0);
    chk(!wr_valid, "R1 wr_valid", wr_valid, 0);

    // R1/R6: first data after reset lands at address 0 with auto-increment
    cmd(8'h40);
    fb[0] = 8'hC0; fb[1] = 8'hA1; fb[2] = 8'hB2; fb[3] = 8'h3C;
    expect_wr(4'h0, 8'hA1, "R6 addr0");
    expect_wr(4'h1, 8'hB2, "R7 auto inc");
    expect_wr(4'h2, 8'h3C, "R2 lsb first");
    frame(4);
    drained("R3 data bytes after command");

    // R10/R12: display control acts before strobe rises
    ser_stb = 1'b0; cyc(4);
    send_bits(8'h8F, 8);
    cyc(8);
    chk(disp_on == 1'b1, "R12 on before strobe rise", disp_on, 1);
    chk(dim_code == 3'd7, "R10 dim code", dim_code, 7);
    ser_stb = 1'b1; cyc(10);

    // R9: same mode keeps display, new mode blanks it
    cmd(8'h03);
    chk(disp_on == 1'b1, "R9 same mode keeps on", disp_on, 1);
    cmd(8'h01);
    chk(scan_mode == 2'b01, "R5 mode value", scan_mode, 1);
    chk(disp_on == 1'b0, "R9 mode change blanks", disp_on, 0);
    cmd(8'h8B);
    chk(disp_on && dim_code == 3'd3, "R10 on dim3", {dim_code, disp_on}, 7);

    // R7: fixed address
    cmd(8'h44);
    fb[0] = 8'hC5; fb[1] = 8'h11; fb[2] = 8'h22;
    expect_wr(4'h5, 8'h11, "R7 fixed first");
    expect_wr(4'h5, 8'h22, "R7 fixed second");
    frame(3);
    drained("R7 fixed drained");

    // R8: increment past 0x0D drops, invalid address drops, valid recovers
    cmd(8'h40);
    fb[0] = 8'hCC; fb[1] = 8'h33; fb[2] = 8'h44; fb[3] = 8'h55;
    expect_wr(4'hC, 8'h33, "R6 addr C");
    expect_wr(4'hD, 8'h44, "R6 addr D");
    frame(4);
    drained("R8 past D dropped");
    fb[0] = 8'hCE; fb[1] = 8'h66; fb[2] = 8'h67;
    frame(3);
    drained("R8 addr E dropped");
    fb[0] = 8'hC3; fb[1] = 8'h77;
    expect_wr(4'h3, 8'h77, "R8 recovery");
    frame(2);
    drained("R8 recovery drained");

    // R4: aborted partial byte is discarded
    ser_stb = 1'b0; cyc(4);
    send_bits(8'h80, 5);
    cyc(4); ser_stb = 1'b1; cyc(10);
    chk(disp_on == 1'b1 && dim_code == 3'd3, "R4 partial ignored", {dim_code, disp_on}, 7);
    cmd(8'h80);
    chk(disp_on == 1'b0 && dim_code == 3'd0, "R4 fresh command", {dim_code, disp_on}, 0);

    // R2: serial clock toggling with strobe high has no effect
    for (int i = 0; i < 12; i++) begin
      ser_clk = 1'b0; ser_dat = i[0]; cyc(4);
      ser_clk = 1'b1; cyc(4);
    end
    chk(disp_on == 1'b0 && scan_mode == 2'b01, "R2 idle clocks ignored",
        {scan_mode, disp_on}, 2);
    fb[0] = 8'hC4; fb[1] = 8'h99;
    expect_wr(4'h4, 8'h99, "R2 aligned after idle clocks");
    frame(2);
    drained("R2 drained");

    // R11: nonzero write selector blocks data, test flag stored
    cmd(8'h49);
    chk(test_mode == 1'b1, "R11 test flag", test_mode, 1);
    fb[0] = 8'hC2; fb[1] = 8'hAA;
    frame(2);
    drained("R11 no write");
    cmd(8'h40);
    chk(test_mode == 1'b0, "R11 test flag cleared", test_mode, 0);
    fb[0] = 8'hC9; fb[1] = 8'h5A;
    expect_wr(4'h9, 8'h5A, "R11 selector 00 writes");
    frame(2);
    drained("R11 drained");

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule